// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer

This block sits between a flat byte-addressed bus and a DRAM. Each accepted request becomes a sequence of timed states on active-low RAS and CAS strobes, with the address split into a row phase and a column phase. A single fast clock drives the block. Each state (precharge, row or column) lasts `TICKS` clocks, so the CAS high time inside the column state can be set to a fraction of the state.

With burst mode on, the block keeps the row of the last access and leaves RAS low between accesses. A request whose row bits match the kept row skips the row phase. This is a fast-page access. A request whose row bits differ first closes the page for one precharge state. With burst mode off, every request is a full access and RAS is released after it. A two-bit shift select sets where the address is split into row and column. The same select also sets which bits the row compare covers. A multiplex enable chooses between shifted row addresses and plain pass-through.

Top module: `dram_addr_mux`

## Requirements
- R1: With `burst_en`=0 every access has a row phase, `page_hit` is 0 at `done`, and `ras_n` returns high after the access.
- R2: With `burst_en`=1 and a valid stored row equal to the request's row bits, the access has no row phase. RAS stays low throughout, only the column state is run (`done` on the 20th clock after acceptance), and `page_hit` is 1 at `done`.
- R3: A burst-mode miss while the page is open holds `ras_n` high for one full state (20 clocks). It then runs a row state and a column state (`done` on the 60th clock after acceptance), and the new row becomes the stored row.
- R4: With `mux_en`=0, `dram_addr` equals the accepted byte address in every state.
- R5: With `mux_en`=1, the row state drives the address shifted right by 8, 9 or 10 bits for `shift_sel` 00, 01 or 10; code 11 acts as 10. The column state drives the unshifted address.
- R6: The burst row compare uses address bits [23:shift] for the selected shift, whatever the value of `mux_en`.
- R7: The column state is 20 clocks long. `cas_n` is high for the first 10 clocks when `duty_sel`=0, or for the first 7 when `duty_sel`=1, and low for the rest. `cas_n` is never low while `ras_n` is high.
- R8: Reset drives `ras_n`, `cas_n` high and `done`, `page_hit` low, and marks the stored row invalid. The first access after reset is a full access (40 clocks with the page closed).
- R9: Any change of `burst_en`, `mux_en`, `shift_sel` or `duty_sel` marks the stored row invalid, so the next access misses.
- R10: `done` is a one-clock pulse in the last clock of the column state, and `page_hit` is valid with it. A closed-page full access ends on clock 40 after acceptance.
- R11: `req` is sampled only when the block is idle. A request raised during an access starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sub-phase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled while idle |
| addr | input | ADDR_W | Byte address of the request |
| burst_en | input | 1 | 1 = keep page open and compare rows |
| mux_en | input | 1 | 1 = drive shifted row address in row state |
| shift_sel | input | 2 | Row shift: 00=8, 01=9, 10/11=10 bits |
| duty_sel | input | 1 | CAS high time: 0 = 50 %, 1 = 35 % of column state |
| dram_addr | output | ADDR_W | Address driven to the DRAM |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| page_hit | output | 1 | Last accepted access was a fast-page access |
| done | output | 1 | One-clock pulse ending each access |

## Verification
The hardest situation to reach is a page hit. It needs burst mode on, an unchanged configuration since the previous access, and a row match under the selected shift width. The vector table therefore orders its accesses so that each configuration change is followed by a miss that loads a row, and then by hits at addresses that differ only below the shift point. That includes one address that matches under a 9-bit shift but would miss under an 8-bit one. Directed tests then reset in the middle of an open-page access, and raise a request in the middle of a transfer.

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int ADDR_W    = 24,
  parameter int TICKS     = 20,
  parameter int HI_WIDE   = 10,
  parameter int HI_NARROW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_en,
  input  logic              mux_en,
  input  logic [1:0]        shift_sel,
  input  logic              duty_sel,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              page_hit,
  output logic              done
);
  localparam int TW = $clog2(TICKS);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_ROW, S_COL} st_t;

  function automatic int shift_of(input logic [1:0] sel);
    return (sel == 2'b00) ? 8 : (sel == 2'b01) ? 9 : 10;
  endfunction

  st_t               state;
  logic [TW-1:0]     tick;
  logic [ADDR_W-1:0] addr_s, row_q;
  logic [4:0]        cfg_q, cfg_s;
  logic              valid, page_open, hit_q;

  logic [4:0] cfg;
  logic       cfg_chg, busy, accept, last, hit_now, burst_s;
  logic [ADDR_W-1:0] live_row, held_row;

  assign cfg      = {burst_en, mux_en, shift_sel, duty_sel};
  assign cfg_chg  = cfg != cfg_q;
  assign busy     = state != S_IDLE;
  assign accept   = !busy && req;
  assign last     = tick == TW'(TICKS - 1);
  assign burst_s  = cfg_s[4];
  assign live_row = addr >> shift_of(shift_sel);
  assign held_row = addr_s >> shift_of(cfg_s[2:1]);
  assign hit_now  = burst_en && valid && !cfg_chg && (live_row == row_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tick      <= '0;
      addr_s    <= '0;
      row_q     <= '0;
      cfg_q     <= '0;
      cfg_s     <= '0;
      valid     <= 1'b0;
      page_open <= 1'b0;
      hit_q     <= 1'b0;
    end else begin
      cfg_q <= cfg;
      if (accept) begin
        addr_s <= addr;
        cfg_s  <= cfg;
        hit_q  <= hit_now;
        tick   <= '0;
        state  <= hit_now ? S_COL : (page_open ? S_PRE : S_ROW);
      end else if (busy) begin
        if (last) begin
          tick <= '0;
          case (state)
            S_PRE:   state <= S_ROW;
            S_ROW:   state <= S_COL;
            default: state <= S_IDLE;
          endcase
        end else begin
          tick <= tick + TW'(1);
        end
      end

      if (done) begin
        row_q     <= held_row;
        page_open <= burst_s;
      end

      if (cfg_chg)   valid <= 1'b0;
      else if (done) valid <= burst_s && (cfg == cfg_s);
    end
  end

  always_comb begin
    case (state)
      S_IDLE:  ras_n = !page_open;
      S_PRE:   ras_n = 1'b1;
      default: ras_n = 1'b0;
    endcase
  end

  assign cas_n     = (state == S_COL) ? (tick < TW'(cfg_s[0] ? HI_NARROW : HI_WIDE)) : 1'b1;
  assign dram_addr = (state == S_ROW && cfg_s[3]) ? held_row : addr_s;
  assign done      = (state == S_COL) && last;
  assign page_hit  = hit_q;
endmodule

// File: rtl/dram_addr_mux_chk.sv
module dram_addr_mux_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              busy,
  input logic              done,
  input logic              page_hit,
  input logic              ras_n,
  input logic              cas_n,
  input logic              burst_s,
  input logic              cfg_chg,
  input logic              valid,
  input logic [ADDR_W-1:0] addr_s
);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_cas_under_ras_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  assert_hit_needs_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && page_hit) |-> burst_s);

  assert_change_invalidates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !valid);

  assert_busy_ignores_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> $stable(addr_s));
endmodule

bind dram_addr_mux dram_addr_mux_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
  .page_hit(page_hit), .ras_n(ras_n), .cas_n(cas_n), .burst_s(burst_s),
  .cfg_chg(cfg_chg), .valid(valid), .addr_s(addr_s)
);

// File: tb/test_dram_addr_mux.sv
module test_dram_addr_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [23:0] addr = '0;
  logic        burst_en = 1'b0, mux_en = 1'b0, duty_sel = 1'b0;
  logic [1:0]  shift_sel = 2'b00;
  logic [23:0] dram_addr;
  logic        ras_n, cas_n, page_hit, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dram_addr_mux i_dram_addr_mux (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr),
    .burst_en(burst_en), .mux_en(mux_en), .shift_sel(shift_sel), .duty_sel(duty_sel),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .page_hit(page_hit), .done(done)
  );

  typedef struct packed {
    logic [23:0] a;
    logic        b, m;
    logic [1:0]  s;
    logic        d;
    logic [7:0]  lat;
    logic        hit;
    logic [23:0] radr;
    logic [7:0]  rh;
    logic [7:0]  cl;
  } vec_t;

  // addr, burst, mux, shift, duty | latency, hit, first addr with RAS low, RAS-high clocks, CAS-low clocks
  localparam vec_t VEC [0:18] = '{
    '{24'h123456, 1'b0, 1'b0, 2'd0, 1'b0, 8'd40, 1'b0, 24'h123456, 8'd0,  8'd10}, // R1 R4
    '{24'h123456, 1'b0, 1'b0, 2'd0, 1'b0, 8'd40, 1'b0, 24'h123456, 8'd0,  8'd10}, // R1 same row
    '{24'h123456, 1'b1, 1'b1, 2'd0, 1'b0, 8'd40, 1'b0, 24'h001234, 8'd0,  8'd10}, // R9 R5
    '{24'h1234AB, 1'b1, 1'b1, 2'd0, 1'b0, 8'd20, 1'b1, 24'h1234AB, 8'd0,  8'd10}, // R2
    '{24'h123556, 1'b1, 1'b1, 2'd0, 1'b0, 8'd60, 1'b0, 24'h001235, 8'd20, 8'd10}, // R3
    '{24'h123599, 1'b1, 1'b1, 2'd0, 1'b0, 8'd20, 1'b1, 24'h123599, 8'd0,  8'd10}, // R3 row updated
    '{24'h123599, 1'b1, 1'b1, 2'd0, 1'b1, 8'd60, 1'b0, 24'h001235, 8'd20, 8'd13}, // R9 R7
    '{24'h123599, 1'b1, 1'b1, 2'd1, 1'b1, 8'd60, 1'b0, 24'h00091A, 8'd20, 8'd13}, // R5 shift 9
    '{24'h1235FF, 1'b1, 1'b1, 2'd1, 1'b1, 8'd20, 1'b1, 24'h1235FF, 8'd0,  8'd13},
    '{24'h123400, 1'b1, 1'b1, 2'd1, 1'b1, 8'd20, 1'b1, 24'h123400, 8'd0,  8'd13}, // R6 bit 8 ignored
    '{24'h123400, 1'b1, 1'b1, 2'd2, 1'b1, 8'd60, 1'b0, 24'h00048D, 8'd20, 8'd13}, // R5 shift 10
    '{24'h1237FF, 1'b1, 1'b1, 2'd2, 1'b1, 8'd20, 1'b1, 24'h1237FF, 8'd0,  8'd13}, // R6
    '{24'h1237FF, 1'b1, 1'b1, 2'd3, 1'b1, 8'd60, 1'b0, 24'h00048D, 8'd20, 8'd13}, // R5 code 11
    '{24'h123400, 1'b1, 1'b1, 2'd3, 1'b1, 8'd20, 1'b1, 24'h123400, 8'd0,  8'd13},
    '{24'h123400, 1'b1, 1'b0, 2'd0, 1'b0, 8'd60, 1'b0, 24'h123400, 8'd20, 8'd10}, // R4 R9
    '{24'h1234FF, 1'b1, 1'b0, 2'd0, 1'b0, 8'd20, 1'b1, 24'h1234FF, 8'd0,  8'd10}, // R6 mux off
    '{24'h1244FF, 1'b1, 1'b0, 2'd0, 1'b0, 8'd60, 1'b0, 24'h1244FF, 8'd20, 8'd10},
    '{24'h1244FF, 1'b0, 1'b0, 2'd0, 1'b0, 8'd60, 1'b0, 24'h1244FF, 8'd20, 8'd10}, // R1 closes page
    '{24'h1244FF, 1'b0, 1'b0, 2'd0, 1'b0, 8'd40, 1'b0, 24'h1244FF, 8'd0,  8'd10}  // R1
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  int lat, rh, cl, hitv;
  logic [23:0] radr;
  logic got_radr;

  task automatic run_access(input logic [23:0] a, input logic b, input logic m,
                            input logic [1:0] s, input logic d);
    @(negedge clk);
    addr = a; burst_en = b; mux_en = m; shift_sel = s; duty_sel = d; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    lat = 0; rh = 0; cl = 0; hitv = 0; radr = '0; got_radr = 1'b0;
    for (int n = 1; n <= 200; n++) begin
      lat = n;
      if (ras_n) rh++;
      if (!cas_n) cl++;
      if (!ras_n && !got_radr) begin radr = dram_addr; got_radr = 1'b1; end
      if (done) begin hitv = page_hit; break; end
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8: reset values
    repeat (3) @(negedge clk);
    chk("R8", "ras_n in reset", ras_n, 1);
    chk("R8", "cas_n in reset", cas_n, 1);
    chk("R8", "done in reset", done, 0);
    chk("R8", "page_hit in reset", page_hit, 0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      run_access(VEC[i].a, VEC[i].b, VEC[i].m, VEC[i].s, VEC[i].d);
      chk("R10", $sformatf("v%0d latency", i), lat, VEC[i].lat);
      chk(VEC[i].b ? "R2/R6" : "R1", $sformatf("v%0d page_hit", i), hitv, VEC[i].hit);
      chk(VEC[i].m ? "R5" : "R4", $sformatf("v%0d address", i), radr, VEC[i].radr);
      chk("R3", $sformatf("v%0d ras high clocks", i), rh, VEC[i].rh);
      chk("R7", $sformatf("v%0d cas low clocks", i), cl, VEC[i].cl);
    end
    @(negedge clk);
    chk("R1", "ras_n released after full access", ras_n, 1);

    // R11: request during an access starts nothing
    begin
      int extra_done, ras_low;
      @(negedge clk);
      addr = 24'h00ABCD; burst_en = 1'b0; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (4) @(negedge clk);
      addr = 24'h0FFFFF; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      lat = 6;
      while (!done && lat < 200) begin @(negedge clk); lat++; end
      chk("R11", "first access latency", lat, 40);
      chk("R11", "address held during access", dram_addr, 24'h00ABCD);
      extra_done = 0; ras_low = 0;
      for (int n = 0; n < 70; n++) begin
        @(negedge clk);
        if (done) extra_done++;
        if (!ras_n) ras_low++;
      end
      chk("R11", "done pulses after busy request", extra_done, 0);
      chk("R11", "ras low clocks after busy request", ras_low, 0);
    end

    // R8: reset with an open page, then the same row must be a full access
    run_access(24'h123456, 1'b1, 1'b1, 2'd0, 1'b0);
    chk("R8", "setup access latency", lat, 40);
    @(negedge clk);
    chk("R8", "page open before reset", ras_n, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8", "ras_n after mid-run reset", ras_n, 1);
    chk("R8", "page_hit after mid-run reset", page_hit, 0);
    rst_n = 1'b1;
    run_access(24'h123456, 1'b1, 1'b1, 2'd0, 1'b0);
    chk("R8", "first access after reset latency", lat, 40);
    chk("R8", "first access after reset page_hit", hitv, 0);
    run_access(24'h1234EE, 1'b1, 1'b1, 2'd0, 1'b0);
    chk("R2", "hit after reset reload", hitv, 1);
    chk("R2", "hit latency after reload", lat, 20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule